// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator with Keyboard Wake Latch

This block gathers interrupt sources into a 16-bit status word. A host on a simple register bus can read that word and can enable or disable each source through a 16-bit mask register with the same bit layout. A single request line, `irq_out`, is high whenever any active source is also enabled in the mask.

Two of the sources are level signals that come from a serial-port block: one for receive and one for transmit. They appear in the status word as they are, with no storage. The third source is a keyboard wake request. It is taken as the OR of an 8-bit input port. A configuration pin chooses whether only the low six lines or all eight lines take part. Once any chosen line is seen high, the request is held in a sticky latch. The latch clears only when the host writes, with any data, to a separate acknowledge address.

Top module: `irq_mask_agg`

## Requirements
- R1: A synchronous active-low reset clears the mask register and the keyboard latch. During and after reset, with the serial sources low, `irq_out` is 0 and the status word reads 0.
- R2: Status bit 13 equals `ser_rx_irq` and status bit 12 equals `ser_tx_irq` in the same cycle. Status bits 15:14 and 11:1 always read 0. The status word is read at `bus_addr` = 0.
- R3: A write to `bus_addr` = 1 loads the mask. Only bits 13, 12 and 0 are stored. The other bits read back as 0 at `bus_addr` = 1 from the next cycle onward.
- R4: `irq_out` is 1 exactly when the bitwise AND of the status word and the mask is non-zero. It follows in the same cycle.
- R5: When `kbd_wide` = 0, the keyboard latch (status bit 0) sets on the clock edge after any of `kbd_port[5:0]` is seen high. `kbd_port[7:6]` have no effect.
- R6: When `kbd_wide` = 1, any of `kbd_port[7:0]` being high sets the keyboard latch on the next clock edge.
- R7: The keyboard latch stays set after the port lines return low, until it is acknowledged.
- R8: Any write to `bus_addr` = 2 clears the keyboard latch on that edge, whatever the write data. If the selected OR is still high in the following cycle, the latch sets again one edge later.
- R9: Writes to `bus_addr` = 0 or 3 change neither the mask nor the latch. Reads at `bus_addr` = 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 status, 1 mask, 2 keyboard acknowledge |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| kbd_port | input | 8 | Keyboard port input lines |
| kbd_wide | input | 1 | 1: all eight lines feed the wake OR; 0: only lines 5:0 do |
| ser_rx_irq | input | 1 | Serial receive interrupt level |
| ser_tx_irq | input | 1 | Serial transmit interrupt level |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
The case that is hardest to reach from the ports is an acknowledge write that arrives while the selected port lines are still high. The latch must read 0 for exactly one cycle and then set again. The directed stimulus holds a port line high across the acknowledge and samples the status word in both following cycles. The random phase uses the same pattern with mixed port values and `kbd_wide` settings. It also covers ignored lines 7:6 in narrow mode, because they can set nothing. This is checked only by reading bit 0 after stimulus that uses those lines alone.

// File: rtl/irq_mask_agg_pkg.sv
// Package: shared widths, bit positions and register selects for the
// interrupt aggregator. Assumes a 16-bit status/mask word.
package irq_mask_agg_pkg;
    localparam int STAT_W  = 16;
    localparam int RX_POS  = 13;
    localparam int TX_POS  = 12;
    localparam int KBD_POS = 0;
    localparam int ADDR_W  = 2;

    // Bits that exist in both the status word and the mask register.
    localparam logic [STAT_W-1:0] IMPL_BITS =
        (STAT_W'(1) << RX_POS) | (STAT_W'(1) << TX_POS) | (STAT_W'(1) << KBD_POS);

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_KBD_ACK = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/kbd_wake_latch.sv
// Keyboard wake latch: ORs the lower NARROW_N port lines, or all PORT_W
// lines when wide_en is high, into a sticky pending flag. An acknowledge
// pulse clears the flag on that edge and wins over a set in the same cycle.
// Assumes the port lines are already synchronous to clk.
module kbd_wake_latch #(
    parameter int PORT_W   = 8,
    parameter int NARROW_N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              wide_en,
    input  logic              ack_wr,
    output logic              pend
);
    logic [PORT_W-1:0] line_en;
    logic              wake_now;

    // Per-line enable: low lines always take part, upper ones only in wide mode.
    for (genvar i = 0; i < PORT_W; i++) begin : g_line
        if (i < NARROW_N) begin : g_fixed
            assign line_en[i] = 1'b1;
        end else begin : g_opt
            assign line_en[i] = wide_en;
        end
    end

    // Selected OR of the enabled port lines.
    assign wake_now = |(port_in & line_en);

    // Sticky pending flag with acknowledge-over-set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (ack_wr) pend <= 1'b0;
        else if (wake_now) pend <= 1'b1;
    end

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_now && !ack_wr) |=> pend);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack_wr) |=> pend);
    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> !pend);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !wake_now) |=> !pend);
endmodule

// File: rtl/irq_mask_store.sv
// Mask register: stores only the implemented bits given by KEEP and holds
// the unused bits at 0. Assumes wr_en is already decoded for this register.
module irq_mask_store #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Load the implemented bits on a write and clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata & KEEP;
    end

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~KEEP) == '0);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_pack.sv
// Status assembly: places the live serial levels and the keyboard latch at
// their bit positions and leaves every other bit at 0. Purely combinational.
module irq_status_pack #(
    parameter int W       = 16,
    parameter int RX_BIT  = 13,
    parameter int TX_BIT  = 12,
    parameter int KBD_BIT = 0
) (
    input  logic         rx_lvl,
    input  logic         tx_lvl,
    input  logic         kbd_pend,
    output logic [W-1:0] status
);
    // Build the status word from the three sources.
    always_comb begin
        status          = '0;
        status[RX_BIT]  = rx_lvl;
        status[TX_BIT]  = tx_lvl;
        status[KBD_BIT] = kbd_pend;
    end
endmodule

// File: rtl/irq_mask_agg.sv
// Interrupt aggregator top: decodes the register selects, holds the mask,
// latches the keyboard wake and drives the combined masked request.
// Assumes a single-cycle write strobe and a combinational read path.
module irq_mask_agg
    import irq_mask_agg_pkg::*;
#(
    parameter int KBD_W      = 8,
    parameter int KBD_NARROW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    input  logic [KBD_W-1:0]  kbd_port,
    input  logic              kbd_wide,
    input  logic              ser_rx_irq,
    input  logic              ser_tx_irq,
    output logic              irq_out
);
    logic              mask_wr;
    logic              ack_wr;
    logic              kbd_pend;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] status;

    // Write decode for the mask and the keyboard acknowledge.
    assign mask_wr = bus_wr && (bus_addr == SEL_MASK);
    assign ack_wr  = bus_wr && (bus_addr == SEL_KBD_ACK);

    kbd_wake_latch #(.PORT_W(KBD_W), .NARROW_N(KBD_NARROW)) u_kbd (
        .clk(clk), .rst_n(rst_n), .port_in(kbd_port), .wide_en(kbd_wide),
        .ack_wr(ack_wr), .pend(kbd_pend)
    );

    irq_mask_store #(.W(STAT_W), .KEEP(IMPL_BITS)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(bus_wdata),
        .mask_q(mask_q)
    );

    irq_status_pack #(.W(STAT_W), .RX_BIT(RX_POS), .TX_BIT(TX_POS),
                      .KBD_BIT(KBD_POS)) u_pack (
        .rx_lvl(ser_rx_irq), .tx_lvl(ser_tx_irq), .kbd_pend(kbd_pend),
        .status(status)
    );

    // Combined request from enabled, active sources.
    assign irq_out = |(status & mask_q);

    // Read multiplexer over the register selects.
    always_comb begin
        case (bus_addr)
            SEL_STATUS: bus_rdata = status;
            SEL_MASK:   bus_rdata = mask_q;
            default:    bus_rdata = '0;
        endcase
    end

    assert_status_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_STATUS) |-> ((bus_rdata & ~IMPL_BITS) == '0));
    assert_masked_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0) && !kbd_pend);
endmodule

// File: tb/irq_mask_agg_test.sv
`timescale 1ns/1ps
module irq_mask_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  kbd_port = '0;
    logic        kbd_wide = 1'b0;
    logic        ser_rx_irq = 1'b0;
    logic        ser_tx_irq = 1'b0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_mask = '0;
    logic        m_latch = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_agg uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_port(kbd_port),
        .kbd_wide(kbd_wide), .ser_rx_irq(ser_rx_irq), .ser_tx_irq(ser_tx_irq),
        .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_status();
        return (16'(ser_rx_irq) << 13) | (16'(ser_tx_irq) << 12) | 16'(m_latch);
    endfunction

    function automatic logic [15:0] exp_rdata();
        case (bus_addr)
            2'd0:    return exp_status();
            2'd1:    return m_mask;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_wake();
        return kbd_wide ? (|kbd_port) : (|kbd_port[5:0]);
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare before the rising
    // edge, then advance the bench model at the rising edge.
    task automatic cyc(string tag, logic [1:0] a, logic w, logic [15:0] d,
                       logic [7:0] p, logic wide, logic rx, logic tx);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        kbd_port = p; kbd_wide = wide; ser_rx_irq = rx; ser_tx_irq = tx;
        #1;
        check({tag, " rdata"}, bus_rdata, exp_rdata());
        check("R4 irq", {15'b0, irq_out}, {15'b0, |(exp_status() & m_mask)});
        @(posedge clk);
        if (!rst_n) begin
            m_mask = '0; m_latch = 1'b0;
        end else begin
            if (w && a == 2'd1) m_mask = d & 16'h3001;
            if (w && a == 2'd2) m_latch = 1'b0;
            else if (exp_wake()) m_latch = 1'b1;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0;
        cyc("R1", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R1", 2'd1, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc("R1", 2'd1, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R3: only bits 13, 12, 0 stored
        cyc("R3", 2'd1, 1'b1, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R3", 2'd1, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R2: live serial bits
        cyc("R2", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b1, 1'b0);
        cyc("R2", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b1);
        // R4: masked source gives no request
        cyc("R4", 2'd1, 1'b1, 16'h1000, 8'h00, 1'b0, 1'b1, 1'b0);
        cyc("R4", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b1, 1'b0);
        cyc("R4", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b1);
        cyc("R4", 2'd1, 1'b1, 16'h0001, 8'h00, 1'b0, 1'b0, 1'b0);
        // R5: narrow mode ignores lines 7:6
        cyc("R5", 2'd0, 1'b0, 16'h0, 8'hC0, 1'b0, 1'b0, 1'b0);
        cyc("R5", 2'd0, 1'b0, 16'h0, 8'hC0, 1'b0, 1'b0, 1'b0);
        cyc("R5", 2'd0, 1'b0, 16'h0, 8'h20, 1'b0, 1'b0, 1'b0);
        // R7: sticky after release
        cyc("R7", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R7", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R8: acknowledge with arbitrary data clears
        cyc("R8", 2'd2, 1'b1, 16'hA5A5, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R8", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R6: wide mode, line 7 sets
        cyc("R6", 2'd0, 1'b0, 16'h0, 8'h80, 1'b1, 1'b0, 1'b0);
        cyc("R6", 2'd0, 1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 1'b0);
        // R8: acknowledge while line held high -> 0 then 1
        cyc("R8", 2'd2, 1'b1, 16'h0000, 8'h80, 1'b1, 1'b0, 1'b0);
        cyc("R8", 2'd0, 1'b0, 16'h0, 8'h80, 1'b1, 1'b0, 1'b0);
        cyc("R8", 2'd0, 1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 1'b0);
        // R9: writes to status and spare selects change nothing
        cyc("R9", 2'd0, 1'b1, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R9", 2'd3, 1'b1, 16'hFFFF, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R9", 2'd2, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R9", 2'd1, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        cyc("R9", 2'd0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 1'b0);
        // Random phase: port mostly idle so the latch is seen both ways
        for (int i = 0; i < 600; i++) begin
            logic [7:0] p;
            logic       w;
            p = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            w = ($urandom_range(0, 4) == 0);
            cyc("R2/R5/R6/R8 rnd", 2'($urandom), w, 16'($urandom), p,
                1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule